// File: doc/BRIEF.md
# Multi-Mode DMA Address Sequencer

This block produces the byte address sequence for one side of a DMA transfer, either the read side or the write side. A start pulse loads a configuration: a base address, an element size code, an addressing mode, the number of elements in a frame, the number of frames in a block, a signed element skip, a signed frame skip and a repeat count. The sequencer then presents the address of the current element. Each step strobe marks that element as accessed, and the sequencer moves to the next address according to the selected mode.

The sequencer tracks where it is within the frame and within the block. It reports the end of each frame, the end of each block and the end of the whole transfer with one-cycle strobes. A block can be re-run a fixed number of times or without end. Each new pass starts again at the base address. The surrounding channel logic issues the bus accesses and moves the data. It uses the address output while the valid flag is high, and it pulses the step strobe once per completed element.

Top module: `dma_addr_gen`

## Requirements
- R1: A start pulse loads the configuration. One cycle later, valid is high, the address equals the base address and no strobe is set. A start in the same cycle as a step wins, and the step is dropped.
- R2: The mode codes are 0 = constant, 1 = post-increment, 2 = post-decrement, 3 = one-dimensional stride and 4 = two-dimensional stride. In constant mode the address never changes from the base address.
- R3: The element size code 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes. Post-increment adds the element size per accepted step. Post-decrement subtracts it.
- R4: In one-dimensional stride mode, every accepted step adds the element size plus the signed element skip.
- R5: In two-dimensional stride mode, a step within a frame adds the element size plus the element skip. The step that consumes the last element of a frame also adds the signed frame skip.
- R6: frame_done pulses for one cycle, one cycle after the step that consumes the last element of a frame. block_done pulses, together with frame_done, after the step that consumes the last element of the block. An element or frame count of 0 behaves as 1.
- R7: A repeat count of 0 runs the block once, and n runs it n+1 times. Any negative count repeats the block without end. Every new pass restarts at the base address.
- R8: done pulses for one cycle with the final block_done, and valid drops at the same time. While valid is low, steps are ignored: the address holds and no strobe fires. While valid is high and no step arrives, the address holds. After reset, valid, all strobes and the address are zero.
- R9: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load configuration and begin a transfer |
| step_i | input | 1 | Current element has been accessed |
| cfg_base_i | input | 32 | Base byte address |
| cfg_esize_i | input | 2 | Element size code (1/2/4/8 bytes) |
| cfg_mode_i | input | 3 | Addressing mode code |
| cfg_elems_i | input | 8 | Elements per frame |
| cfg_frames_i | input | 8 | Frames per block |
| cfg_eskip_i | input | 32 | Signed element skip in bytes |
| cfg_fskip_i | input | 32 | Signed frame skip in bytes |
| cfg_repeat_i | input | 8 | Signed repeat count, negative means endless |
| addr_o | output | 32 | Current element address |
| valid_o | output | 1 | Transfer in progress, address meaningful |
| frame_done_o | output | 1 | Last element of a frame consumed |
| block_done_o | output | 1 | Last element of a block consumed |
| done_o | output | 1 | Final element of the transfer consumed |

## Verification
A wrong element or frame counter shows up first in the frame and block strobes. It appears one cycle after the step that should, or should not, have ended the frame. In two-dimensional mode the same fault also shifts the address, because the frame skip gets applied at the wrong step. A wrong stride or sign shows in the address on the very next element. A wrong repeat counter only appears at a block boundary: the address fails to reload to the base, or done fires one pass early or late. The sweep therefore compares every address and every strobe on every step, over every mode, element size and small frame shape.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [2:0] {
    AM_FIXED  = 3'd0,
    AM_INC    = 3'd1,
    AM_DEC    = 3'd2,
    AM_STRIDE = 3'd3,
    AM_PLANE  = 3'd4
  } addr_mode_e;

  localparam int unsigned ESZ_CODE_W = 2;
  localparam int unsigned MODE_W     = 3;

endpackage

// File: rtl/dag_stride.sv
module dag_stride
  import dag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  addr_mode_e            mode,
  input  logic [ESZ_CODE_W-1:0] esz_code,
  input  logic [AW-1:0]         eskip,
  input  logic [AW-1:0]         fskip,
  output logic [AW-1:0]         elem_delta,
  output logic [AW-1:0]         frame_delta
);

  logic [AW-1:0] esz_bytes;

  always_comb begin
    esz_bytes = AW'(1) << esz_code;
  end

  always_comb begin
    unique case (mode)
      AM_INC:              elem_delta = esz_bytes;
      AM_DEC:              elem_delta = '0 - esz_bytes;
      AM_STRIDE, AM_PLANE: elem_delta = esz_bytes + eskip;
      default:             elem_delta = '0;
    endcase
  end

  always_comb begin
    if (mode == AM_PLANE) frame_delta = elem_delta + fskip;
    else                  frame_delta = elem_delta;
  end

endmodule

// File: rtl/dag_position.sv
module dag_position #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic [CW-1:0] elems_cfg,
  input  logic [CW-1:0] frames_cfg,
  output logic          elem_last,
  output logic          frame_last
);

  logic [CW-1:0] elem_q, elem_d;
  logic [CW-1:0] frame_q, frame_d;
  logic [CW-1:0] elem_lim, frame_lim;
  logic          cnt_en;

  always_comb begin
    elem_lim   = (elems_cfg  == '0) ? '0 : elems_cfg  - CW'(1);
    frame_lim  = (frames_cfg == '0) ? '0 : frames_cfg - CW'(1);
    elem_last  = (elem_q  >= elem_lim);
    frame_last = (frame_q >= frame_lim);
  end

  always_comb begin
    cnt_en  = clear | advance;
    elem_d  = elem_q;
    frame_d = frame_q;
    if (clear) begin
      elem_d  = '0;
      frame_d = '0;
    end else if (advance) begin
      if (elem_last) begin
        elem_d  = '0;
        frame_d = frame_last ? '0 : frame_q + CW'(1);
      end else begin
        elem_d  = elem_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q  <= '0;
      frame_q <= '0;
    end else if (cnt_en) begin
      elem_q  <= elem_d;
      frame_q <= frame_d;
    end
  end

endmodule

// File: rtl/dag_repeat.sv
module dag_repeat #(
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] rep_cfg,
  input  logic          consume,
  output logic          more
);

  logic [RW-1:0] rem_q, rem_d;
  logic          endless_q, endless_d;
  logic          rep_en;

  always_comb begin
    more = endless_q | (rem_q != '0);
  end

  always_comb begin
    rep_en    = load | consume;
    rem_d     = rem_q;
    endless_d = endless_q;
    if (load) begin
      endless_d = rep_cfg[RW-1];
      rem_d     = rep_cfg[RW-1] ? '0 : rep_cfg;
    end else if (consume && !endless_q && rem_q != '0) begin
      rem_d     = rem_q - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q     <= '0;
      endless_q <= 1'b0;
    end else if (rep_en) begin
      rem_q     <= rem_d;
      endless_q <= endless_d;
    end
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  step_i,
  input  logic [AW-1:0]         cfg_base_i,
  input  logic [ESZ_CODE_W-1:0] cfg_esize_i,
  input  logic [MODE_W-1:0]     cfg_mode_i,
  input  logic [CNT_W-1:0]      cfg_elems_i,
  input  logic [CNT_W-1:0]      cfg_frames_i,
  input  logic [AW-1:0]         cfg_eskip_i,
  input  logic [AW-1:0]         cfg_fskip_i,
  input  logic [REP_W-1:0]      cfg_repeat_i,
  output logic [AW-1:0]         addr_o,
  output logic                  valid_o,
  output logic                  frame_done_o,
  output logic                  block_done_o,
  output logic                  done_o
);

  // latched configuration
  logic [AW-1:0]         base_q;
  addr_mode_e            mode_q;
  logic [ESZ_CODE_W-1:0] esz_q;
  logic [CNT_W-1:0]      elems_q, frames_q;
  logic [AW-1:0]         eskip_q, fskip_q;

  // run state
  logic [AW-1:0] addr_q, addr_d;
  logic          valid_q, valid_d;
  logic          fd_q, fd_d, bd_q, bd_d, dn_q, dn_d;
  logic          addr_en;

  logic [AW-1:0] elem_delta, frame_delta;
  logic          elem_last, frame_last, more;
  logic          accept, blk_end;

  dag_stride #(.AW(AW)) stride_i (
    .mode        (mode_q),
    .esz_code    (esz_q),
    .eskip       (eskip_q),
    .fskip       (fskip_q),
    .elem_delta  (elem_delta),
    .frame_delta (frame_delta)
  );

  dag_position #(.CW(CNT_W)) pos_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_i),
    .advance    (accept),
    .elems_cfg  (elems_q),
    .frames_cfg (frames_q),
    .elem_last  (elem_last),
    .frame_last (frame_last)
  );

  dag_repeat #(.RW(REP_W)) rep_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_i),
    .rep_cfg (cfg_repeat_i),
    .consume (blk_end),
    .more    (more)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      mode_q   <= AM_FIXED;
      esz_q    <= '0;
      elems_q  <= '0;
      frames_q <= '0;
      eskip_q  <= '0;
      fskip_q  <= '0;
    end else if (start_i) begin
      base_q   <= cfg_base_i;
      mode_q   <= addr_mode_e'(cfg_mode_i);
      esz_q    <= cfg_esize_i;
      elems_q  <= cfg_elems_i;
      frames_q <= cfg_frames_i;
      eskip_q  <= cfg_eskip_i;
      fskip_q  <= cfg_fskip_i;
    end
  end

  always_comb begin
    accept  = step_i & valid_q & ~start_i;
    blk_end = accept & elem_last & frame_last;
    addr_en = start_i | accept;

    addr_d = addr_q;
    if (start_i)        addr_d = cfg_base_i;
    else if (blk_end)   addr_d = more ? base_q : addr_q;
    else if (accept)    addr_d = elem_last ? addr_q + frame_delta
                                           : addr_q + elem_delta;

    valid_d = valid_q;
    if (start_i)                valid_d = 1'b1;
    else if (blk_end && !more)  valid_d = 1'b0;

    fd_d = accept & elem_last;
    bd_d = blk_end;
    dn_d = blk_end & ~more;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fd_q    <= 1'b0;
      bd_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      fd_q    <= fd_d;
      bd_q    <= bd_d;
      dn_q    <= dn_d;
    end
  end

  assign addr_o       = addr_q;
  assign valid_o      = valid_q;
  assign frame_done_o = fd_q;
  assign block_done_o = bd_q;
  assign done_o       = dn_q;

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          step_i,
  input logic [AW-1:0] cfg_base_i,
  input logic [AW-1:0] addr_o,
  input logic          valid_o,
  input logic          frame_done_o,
  input logic          block_done_o,
  input logic          done_o,
  input logic [2:0]    mode_q
);

  a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && addr_o == $past(cfg_base_i) && !frame_done_o));

  a_r2_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && valid_o && !start_i && mode_q == 3'd0) |=> $stable(addr_o));

  a_r6_block_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
    block_done_o |-> frame_done_o);

  a_r8_done_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!valid_o && block_done_o));

  a_r8_idle_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> ($stable(addr_o) && !frame_done_o && !valid_o));

  a_r8_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !step_i && !start_i) |=> $stable(addr_o));

endmodule

bind dma_addr_gen dag_checker #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .step_i       (step_i),
  .cfg_base_i   (cfg_base_i),
  .addr_o       (addr_o),
  .valid_o      (valid_o),
  .frame_done_o (frame_done_o),
  .block_done_o (block_done_o),
  .done_o       (done_o),
  .mode_q       (mode_q)
);

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i, step_i;
  logic [31:0] cfg_base_i, cfg_eskip_i, cfg_fskip_i;
  logic [1:0]  cfg_esize_i;
  logic [2:0]  cfg_mode_i;
  logic [7:0]  cfg_elems_i, cfg_frames_i, cfg_repeat_i;
  logic [31:0] addr_o;
  logic        valid_o, frame_done_o, block_done_o, done_o;

  int tests = 0;
  int fails = 0;

  dma_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .cfg_base_i(cfg_base_i), .cfg_esize_i(cfg_esize_i), .cfg_mode_i(cfg_mode_i),
    .cfg_elems_i(cfg_elems_i), .cfg_frames_i(cfg_frames_i),
    .cfg_eskip_i(cfg_eskip_i), .cfg_fskip_i(cfg_fskip_i),
    .cfg_repeat_i(cfg_repeat_i), .addr_o(addr_o), .valid_o(valid_o),
    .frame_done_o(frame_done_o), .block_done_o(block_done_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] base, input int esz,
      input int mode, input int ne, input int f, input int e, input int es, input int fs);
    longint idx, off;
    idx = longint'(f) * ne + e;
    case (mode)
      1:       off = idx * esz;
      2:       off = -idx * esz;
      3:       off = idx * (esz + es);
      4:       off = idx * (esz + es) + longint'(f) * fs;
      default: off = 0;
    endcase
    return base + off[31:0];
  endfunction

  function automatic string addr_tag(input int mode);
    case (mode)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic load(input logic [31:0] base, input int escode, input int mode,
      input int ne, input int nf, input int es, input int fs, input int rep);
    cfg_base_i   = base;
    cfg_esize_i  = 2'(escode);
    cfg_mode_i   = 3'(mode);
    cfg_elems_i  = 8'(ne);
    cfg_frames_i = 8'(nf);
    cfg_eskip_i  = 32'(es);
    cfg_fskip_i  = 32'(fs);
    cfg_repeat_i = 8'(rep);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 valid after start", 32'(valid_o), 32'd1);
    chk("R1 no strobe after start", 32'(frame_done_o), 32'd0);
  endtask

  // passes: number of passes to walk; endless: rep is negative
  task automatic walk(input logic [31:0] base, input int escode, input int mode,
      input int ne, input int nf, input int es, input int fs, input int rep);
    int passes;
    bit endless;
    int esz;
    endless = (rep < 0);
    passes  = endless ? 3 : rep + 1;
    esz     = 1 << escode;
    for (int p = 0; p < passes; p++) begin
      for (int f = 0; f < nf; f++) begin
        for (int e = 0; e < ne; e++) begin
          bit lastblk, fin;
          lastblk = (f == nf - 1) && (e == ne - 1);
          fin     = lastblk && !endless && (p == passes - 1);
          chk((p > 0 && f == 0 && e == 0) ? "R7 reload base" : addr_tag(mode),
              addr_o, model_addr(base, esz, mode, ne, f, e, es, fs));
          step_i = 1'b1;
          @(negedge clk);
          step_i = 1'b0;
          chk("R6 frame_done", 32'(frame_done_o), 32'(e == ne - 1));
          chk("R6 block_done", 32'(block_done_o), 32'(lastblk));
          chk("R8 done", 32'(done_o), 32'(fin));
          chk("R7 valid", 32'(valid_o), 32'(!fin));
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; start_i = 1'b0; step_i = 1'b0;
    cfg_base_i = '0; cfg_esize_i = '0; cfg_mode_i = '0; cfg_elems_i = '0;
    cfg_frames_i = '0; cfg_eskip_i = '0; cfg_fskip_i = '0; cfg_repeat_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset valid", 32'(valid_o), 32'd0);
    chk("R8 reset addr", addr_o, 32'd0);
    chk("R8 reset strobes", {29'd0, frame_done_o, block_done_o, done_o}, 32'd0);

    // sweep: every mode, element size and small frame shape
    for (int mode = 0; mode < 5; mode++)
      for (int ec = 0; ec < 4; ec++)
        for (int ne = 1; ne <= 3; ne++)
          for (int nf = 1; nf <= 3; nf++) begin
            int es, fs;
            es = (ec % 2 == 1) ? -6 : 5;
            fs = (nf == 2) ? -40 : 24;
            load(32'h0000_1000 + 32'(mode * 16), ec, mode, ne, nf, es, fs, 0);
            walk(32'h0000_1000 + 32'(mode * 16), ec, mode, ne, nf, es, fs, 0);
          end

    // R7 fixed repeats in 2D mode
    load(32'h2000, 2, 4, 2, 2, 4, 16, 2);
    walk(32'h2000, 2, 4, 2, 2, 4, 16, 2);

    // R8 idle steps ignored after done
    held = addr_o;
    for (int i = 0; i < 3; i++) begin
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      chk("R8 idle addr held", addr_o, held);
      chk("R8 idle no frame strobe", 32'(frame_done_o), 32'd0);
      chk("R8 idle valid low", 32'(valid_o), 32'd0);
    end

    // R9 wrap upward and downward
    load(32'hFFFF_FFF8, 2, 1, 4, 1, 0, 0, 0);
    walk(32'hFFFF_FFF8, 2, 1, 4, 1, 0, 0, 0);
    load(32'h0000_0008, 3, 2, 3, 1, 0, 0, 0);
    walk(32'h0000_0008, 3, 2, 3, 1, 0, 0, 0);

    // R6 zero counts behave as one
    load(32'h3000, 0, 1, 0, 0, 0, 0, 0);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    chk("R6 zero count frame_done", 32'(frame_done_o), 32'd1);
    chk("R6 zero count block_done", 32'(block_done_o), 32'd1);
    chk("R8 zero count done", 32'(done_o), 32'd1);

    // R8 hold without step, then R7 endless
    load(32'h4000, 1, 3, 3, 2, 2, 0, -1);
    repeat (3) @(negedge clk);
    chk("R8 hold without step", addr_o, 32'h4000);
    walk(32'h4000, 1, 3, 3, 2, 2, 0, -1);
    chk("R7 endless still valid", 32'(valid_o), 32'd1);

    // R1 start wins over a simultaneous step
    step_i = 1'b1;
    load(32'h5550, 0, 1, 2, 1, 0, 0, 0);
    step_i = 1'b0;
    chk("R1 start priority addr", addr_o, 32'h5550);
    walk(32'h5550, 0, 1, 2, 1, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule